// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Controller

This block is the control part of one DMA channel. Software programs the channel through a small register write port and then writes a configuration word with its enable bit set. The channel then takes one of three paths, chosen by a two-bit mode field in that word. In the first path it moves data at once, using the register-written parameters. In the second it first loads the start address, X count and Y count from a descriptor in memory. In the third it also loads a configuration byte from the descriptor, and that byte replaces the transfer fields written by software.

The channel reaches memory over a simple request/grant bus. A word or data element moves only in a cycle where the channel's request and the grant are both high. Descriptor words are 16-bit reads. For each data element the block presents the element address and marks the access as a memory write (receive) or a memory read (transmit). The block tracks a run bit and a descriptor-fetch bit. On the first data access it fills the current address and count registers from the start registers, and it then steps the address in one or two dimensions. It can raise a one-cycle completion pulse after a row or after the whole work unit. The arbiter, FIFO storage and peripheral handshakes sit outside this block.

Top module: `dmach_ctrl`

## Requirements
- R1: After reset the status read (read address 1: bit0 run, bit1 fetch) is 0 and bus_req is 0. A write to the configuration register (write address 0) with bit0 = 1 while idle sets run. It also sets fetch when the mode field bits[9:8] is 1 or 2. The status read issued in the cycle after the write shows the new bits.
- R2: In mode 0 no descriptor is fetched. Data accesses begin right away and use the register-written start address (write addresses 3/4), X count (5), Y count (6) and configuration.
- R3: In modes 1 and 2 the descriptor is read as 16-bit words at byte addresses ptr, ptr+2, ... The pointer is written at addresses 1 and 2. The word order is: configuration (mode 2 only), start address low, start address high, X count, Y count. The loaded values overwrite the start registers (read addresses 8 to 11). Fetch clears once the last word is loaded, and run stays set.
- R4: In mode 2 the low byte of the fetched configuration word sets direction (bit1), word size (bits[3:2]), 2D (bit4), row-interrupt select (bit5) and interrupt enable (bit6). The register-written values of these fields have no effect. Bit0 of the fetched byte is ignored, and the active byte (read address 6) shows bit0 = 1. In mode 1 the register-written configuration governs the transfer.
- R5: bus_req stays high during fetch and transfer. No word, element, address or count advances in a cycle without bus_gnt.
- R6: The first data access uses the start address. It writes start address + stride, X count - 1 and Y count into the current registers (read addresses 2 to 5). Until that access the current registers keep their earlier values.
- R7: The address advances by a stride of 1, 2 or 4 bytes for word size 0, 1 or 2. Word size 3 also gives a stride of 4.
- R8: In 2D mode, when the X count reaches zero with Y above 1, X reloads from the start X count and Y decrements. A transfer runs X*Y elements and ends with current X = 0 and current Y = 1. In 1D mode it runs X elements and ends with current X = 0 and current Y equal to the start Y count.
- R9: After the grant of the final element, run clears and bus_req drops in the next cycle.
- R10: bus_we is 1 on data accesses when the direction bit is 1 and 0 when it is 0. bus_we is always 0 on descriptor reads, which are marked by bus_kind = 1.
- R11: When interrupt enable is set, done_irq pulses in the cycle after the final element's grant. When row select is also set, it pulses after every row end as well. It never pulses for a descriptor word.
- R12: Register writes of any kind are ignored while run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rd_data | output | 16 | Read data, one cycle after the address |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; an access completes when both are high |
| bus_kind | output | 1 | 1 = descriptor read, 0 = data access |
| bus_we | output | 1 | 1 = memory write for a data element |
| bus_addr | output | 32 | Byte address of the access |
| bus_rdata | input | 16 | Descriptor word, valid in the granted cycle |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
A configuration write takes effect at the edge that captures it. The registered read port returns data one edge after its address is set, so the bench reads status and current registers through a full read cycle after each stimulus. Accesses are logged on the falling edge, when bus_req, bus_gnt, bus_addr and bus_kind are stable. The end of a transfer is timed in cycles: done_irq must appear exactly one cycle after the final logged grant, with bus_req already low. The bench holds the grant low for set windows, so the run, fetch and stale current-register values can be read at known points between the configuration write and the first data access.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef struct packed {
    logic       rsv;
    logic       irq_en;
    logic       irq_row;
    logic       twod;
    logic [1:0] wsize;
    logic       dir_wr;
    logic       en;
  } dcfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DATA  = 2'd2
  } dstate_t;

  localparam int RAW = 4;

  localparam logic [RAW-1:0] W_CFG = 4'd0;
  localparam logic [RAW-1:0] W_DPL = 4'd1;
  localparam logic [RAW-1:0] W_DPH = 4'd2;
  localparam logic [RAW-1:0] W_SAL = 4'd3;
  localparam logic [RAW-1:0] W_SAH = 4'd4;
  localparam logic [RAW-1:0] W_SX  = 4'd5;
  localparam logic [RAW-1:0] W_SY  = 4'd6;

  localparam logic [RAW-1:0] Q_CFG = 4'd0;
  localparam logic [RAW-1:0] Q_STS = 4'd1;
  localparam logic [RAW-1:0] Q_CAL = 4'd2;
  localparam logic [RAW-1:0] Q_CAH = 4'd3;
  localparam logic [RAW-1:0] Q_CX  = 4'd4;
  localparam logic [RAW-1:0] Q_CY  = 4'd5;
  localparam logic [RAW-1:0] Q_ACT = 4'd6;
  localparam logic [RAW-1:0] Q_SAL = 4'd8;
  localparam logic [RAW-1:0] Q_SAH = 4'd9;
  localparam logic [RAW-1:0] Q_SX  = 4'd10;
  localparam logic [RAW-1:0] Q_SY  = 4'd11;

  localparam logic [2:0] SL_CFG = 3'd0;
  localparam logic [2:0] SL_SAL = 3'd1;
  localparam logic [2:0] SL_SAH = 3'd2;
  localparam logic [2:0] SL_SX  = 3'd3;
  localparam logic [2:0] SL_SY  = 3'd4;

  function automatic logic [2:0] stride_of(logic [1:0] ws);
    case (ws)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           idle,
  input  logic [1:0]     status,
  input  logic [AW-1:0]  cur_addr,
  input  logic [DW-1:0]  cur_x,
  input  logic [DW-1:0]  cur_y,
  input  logic           ld_en,
  input  logic [2:0]     ld_slot,
  input  logic [DW-1:0]  ld_data,
  output logic           start,
  output logic [1:0]     start_mode,
  output logic [AW-1:0]  desc_ptr,
  output logic [AW-1:0]  s_addr,
  output logic [DW-1:0]  s_x,
  output logic [DW-1:0]  s_y,
  output dcfg_t          act
);
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rd_mux;
  logic          wr_ok;

  assign wr_ok      = wr_en && idle;
  assign start      = wr_ok && (wr_addr == W_CFG) && wr_data[0];
  assign start_mode = wr_data[9:8];

  always_comb begin
    case (rd_addr)
      Q_CFG:   rd_mux = cfg_q;
      Q_STS:   rd_mux = DW'(status);
      Q_CAL:   rd_mux = cur_addr[DW-1:0];
      Q_CAH:   rd_mux = cur_addr[AW-1:DW];
      Q_CX:    rd_mux = cur_x;
      Q_CY:    rd_mux = cur_y;
      Q_ACT:   rd_mux = DW'(act);
      Q_SAL:   rd_mux = s_addr[DW-1:0];
      Q_SAH:   rd_mux = s_addr[AW-1:DW];
      Q_SX:    rd_mux = s_x;
      Q_SY:    rd_mux = s_y;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      desc_ptr <= '0;
      s_addr   <= '0;
      s_x      <= '0;
      s_y      <= '0;
      act      <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          W_CFG: begin
            cfg_q <= wr_data;
            if (wr_data[0]) act <= dcfg_t'(wr_data[7:0]);
          end
          W_DPL: desc_ptr[DW-1:0]  <= wr_data;
          W_DPH: desc_ptr[AW-1:DW] <= wr_data;
          W_SAL: s_addr[DW-1:0]    <= wr_data;
          W_SAH: s_addr[AW-1:DW]   <= wr_data;
          W_SX:  s_x               <= wr_data;
          W_SY:  s_y               <= wr_data;
          default: ;
        endcase
      end
      if (ld_en) begin
        case (ld_slot)
          SL_CFG: act               <= dcfg_t'({ld_data[7:1], 1'b1});
          SL_SAL: s_addr[DW-1:0]    <= ld_data;
          SL_SAH: s_addr[AW-1:DW]   <= ld_data;
          SL_SX:  s_x               <= ld_data;
          SL_SY:  s_y               <= ld_data;
          default: ;
        endcase
      end
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dmach_fetch.sv
module dmach_fetch
  import dmach_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          arm_has_cfg,
  input  logic          step,
  input  logic [AW-1:0] desc_ptr,
  output logic [AW-1:0] f_addr,
  output logic [2:0]    slot,
  output logic          last
);
  logic [2:0] idx;
  logic       has_cfg;
  logic [2:0] nwords;

  assign nwords = has_cfg ? 3'd5 : 3'd4;
  assign last   = (idx == nwords - 3'd1);
  assign slot   = has_cfg ? idx : idx + 3'd1;
  assign f_addr = desc_ptr + AW'({idx, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      has_cfg <= 1'b0;
    end else if (arm) begin
      idx     <= '0;
      has_cfg <= arm_has_cfg;
    end else if (step) begin
      idx <= idx + 3'd1;
    end
  end
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer #(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          step,
  input  logic          twod,
  input  logic [2:0]    stride,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_x,
  input  logic [DW-1:0] s_y,
  output logic [AW-1:0] elem_addr,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_x,
  output logic [DW-1:0] cur_y,
  output logic          row_end,
  output logic          last
);
  logic          first;
  logic [DW-1:0] bx, by, nx;
  logic          y_more;

  always_comb begin
    elem_addr = first ? s_addr : cur_addr;
    bx        = first ? s_x : cur_x;
    by        = first ? s_y : cur_y;
    nx        = bx - DW'(1);
    row_end   = (nx == '0);
    y_more    = twod && (by > DW'(1));
    last      = row_end && !y_more;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first    <= 1'b0;
      cur_addr <= '0;
      cur_x    <= '0;
      cur_y    <= '0;
    end else if (arm) begin
      first <= 1'b1;
    end else if (step) begin
      first    <= 1'b0;
      cur_addr <= elem_addr + AW'(stride);
      if (row_end && y_more) begin
        cur_x <= s_x;
        cur_y <= by - DW'(1);
      end else begin
        cur_x <= nx;
        cur_y <= by;
      end
    end
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr_en,
  input  logic [RAW-1:0] reg_wr_addr,
  input  logic [DW-1:0]  reg_wr_data,
  input  logic [RAW-1:0] reg_rd_addr,
  output logic [DW-1:0]  reg_rd_data,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_kind,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_rdata,
  output logic           done_irq
);
  dstate_t       state;
  logic          start;
  logic [1:0]    start_mode;
  logic [AW-1:0] desc_ptr, s_addr, f_addr, elem_addr, cur_addr;
  logic [DW-1:0] s_x, s_y, cur_x, cur_y;
  dcfg_t         act;
  logic [2:0]    slot;
  logic          f_last, x_last, x_row_end;
  logic          fetch_step, data_step;

  assign fetch_step = (state == ST_FETCH) && bus_gnt;
  assign data_step  = (state == ST_DATA) && bus_gnt;

  assign bus_req  = (state != ST_IDLE);
  assign bus_kind = (state == ST_FETCH);
  assign bus_we   = (state == ST_DATA) && act.dir_wr;
  assign bus_addr = (state == ST_FETCH) ? f_addr : elem_addr;

  dmach_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .idle(state == ST_IDLE),
    .status({state == ST_FETCH, state != ST_IDLE}),
    .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y),
    .ld_en(fetch_step), .ld_slot(slot), .ld_data(bus_rdata),
    .start(start), .start_mode(start_mode),
    .desc_ptr(desc_ptr), .s_addr(s_addr), .s_x(s_x), .s_y(s_y), .act(act)
  );

  dmach_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst(rst),
    .arm(start), .arm_has_cfg(start_mode == 2'd2),
    .step(fetch_step), .desc_ptr(desc_ptr),
    .f_addr(f_addr), .slot(slot), .last(f_last)
  );

  dmach_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst),
    .arm(start), .step(data_step),
    .twod(act.twod), .stride(stride_of(act.wsize)),
    .s_addr(s_addr), .s_x(s_x), .s_y(s_y),
    .elem_addr(elem_addr), .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y),
    .row_end(x_row_end), .last(x_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done_irq <= 1'b0;
    end else begin
      done_irq <= data_step && act.irq_en && (x_last || (act.irq_row && x_row_end));
      case (state)
        ST_IDLE:  if (start) state <= (start_mode != 2'd0) ? ST_FETCH : ST_DATA;
        ST_FETCH: if (bus_gnt && f_last) state <= ST_DATA;
        ST_DATA:  if (bus_gnt && x_last) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmach_ctrl_chk.sv
module dmach_ctrl_chk #(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_kind,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          done_irq
);
  p_fetch_no_we_r10: assert property (@(posedge clk) disable iff (rst)
    bus_kind |-> !bus_we);

  p_kind_has_req_r5: assert property (@(posedge clk) disable iff (rst)
    bus_kind |-> bus_req);

  p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

  p_fetch_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_kind) |=> (!bus_kind || bus_addr == $past(bus_addr) + AW'(2)));

  p_irq_after_data_r11: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(bus_req && bus_gnt && !bus_kind));
endmodule

bind dmach_ctrl dmach_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_kind(bus_kind), .bus_we(bus_we), .bus_addr(bus_addr), .done_irq(done_irq)
);

// File: tb/dmach_ctrl_test.sv
module dmach_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [15:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [15:0] reg_rd_data;
  logic        bus_req, bus_kind, bus_we, done_irq;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_addr;
  logic [15:0] bus_rdata;

  logic [15:0] desc_mem [0:7];
  logic [31:0] dbase = '0;
  logic [31:0] doff;
  assign doff      = bus_addr - dbase;
  assign bus_rdata = desc_mem[doff[3:1]];

  int nchk = 0, nfail = 0, cyc = 0;
  int nf, nd, nirq, early_irq, last_g, irq_c, f_we;
  logic irq_req;
  logic [31:0] f_addr [0:15];
  logic [31:0] d_addr [0:15];
  logic        d_we   [0:15];

  dmach_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_kind(bus_kind), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .done_irq(done_irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (bus_req && bus_gnt) begin
      if (bus_kind) begin
        if (nf < 16) f_addr[nf] = bus_addr;
        if (bus_we) f_we = f_we + 1;
        nf = nf + 1;
      end else begin
        if (nd < 16) begin d_addr[nd] = bus_addr; d_we[nd] = bus_we; end
        nd = nd + 1;
        last_g = cyc;
      end
    end
    if (done_irq) begin
      nirq = nirq + 1; irq_c = cyc; irq_req = bus_req;
      if (nd == 0) early_irq = early_irq + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    nf = 0; nd = 0; nirq = 0; early_irq = 0; last_g = 0; irq_c = 0; f_we = 0; irq_req = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    reg_rd_addr = a;
    @(posedge clk); #1;
    v = reg_rd_data;
  endtask

  task automatic wait_data(int n);
    while (nd < n) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1 bus_gnt = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(4'd1, v);
    chk("R1 status after reset", v, 0);
    chk("R1 bus_req after reset", bus_req, 0);
  endtask

  task automatic t_reg_1d();
    logic [15:0] v;
    clr_log();
    wr(4'd3, 16'h0100); wr(4'd4, 16'h1000); wr(4'd5, 16'd3); wr(4'd6, 16'd5);
    wr(4'd0, 16'h0047);            // mode 0, en, dir_wr, wsize 1, irq_en
    rd(4'd1, v);
    chk("R1 run set, fetch clear in mode 0", v, 16'h0001);
    chk("R2 request without fetch", {bus_req, bus_kind}, 2'b10);
    chk("R2 first address is start", bus_addr, 32'h1000_0100);
    rd(4'd2, v);
    chk("R6 current addr stale before first access", v, 0);
    bus_gnt = 1'b1; @(posedge clk); #1 bus_gnt = 1'b0;
    rd(4'd2, v); chk("R6 current addr low after first", v, 16'h0102);
    rd(4'd3, v); chk("R6 current addr high after first", v, 16'h1000);
    rd(4'd4, v); chk("R6 current X after first", v, 16'd2);
    rd(4'd5, v); chk("R6 current Y after first", v, 16'd5);
    bus_gnt = 1'b1;
    wait_data(3);
    chk("R5 data element count", nd, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R7 address stride 2", d_addr[i], 32'h1000_0100 + 32'(2 * i));
      chk("R10 memory write direction", d_we[i], 1);
    end
    rd(4'd4, v); chk("R8 1D final X", v, 0);
    rd(4'd5, v); chk("R8 1D final Y keeps start", v, 16'd5);
    rd(4'd2, v); chk("R8 final address", v, 16'h0106);
    rd(4'd1, v); chk("R9 run clear at end", v, 0);
    chk("R11 single end interrupt", nirq, 1);
    chk("R11 interrupt one cycle after last grant", irq_c - last_g, 1);
    chk("R9 request low in cycle after last grant", irq_req, 0);
  endtask

  task automatic t_desc_cfg();
    logic [15:0] v;
    clr_log();
    dbase = 32'h2000_0040;
    desc_mem[0] = 16'h0078;        // dir 0, wsize 2, 2D, row irq, irq_en, bit0 clear
    desc_mem[1] = 16'h0200; desc_mem[2] = 16'h3000;
    desc_mem[3] = 16'd2;    desc_mem[4] = 16'd3;
    wr(4'd1, 16'h0040); wr(4'd2, 16'h2000);
    wr(4'd3, 16'h5555); wr(4'd5, 16'd9); wr(4'd6, 16'd9);
    wr(4'd0, 16'h0203);            // mode 2, en, dir_wr, wsize 0, 1D, no irq
    rd(4'd1, v);
    chk("R1 run and fetch set in mode 2", v, 16'h0003);
    bus_gnt = 1'b1; repeat (5) @(posedge clk); #1 bus_gnt = 1'b0;
    rd(4'd1, v);
    chk("R3 fetch clear after last word", v, 16'h0001);
    chk("R3 five descriptor words", nf, 5);
    for (int i = 0; i < 5; i++)
      chk("R3 descriptor word address", f_addr[i], 32'h2000_0040 + 32'(2 * i));
    chk("R10 no write on descriptor read", f_we, 0);
    rd(4'd8, v);  chk("R3 start low loaded", v, 16'h0200);
    rd(4'd9, v);  chk("R3 start high loaded", v, 16'h3000);
    rd(4'd10, v); chk("R3 start X loaded", v, 16'd2);
    rd(4'd11, v); chk("R3 start Y loaded", v, 16'd3);
    rd(4'd6, v);  chk("R4 active config byte", v, 16'h0079);
    bus_gnt = 1'b1;
    wait_data(6);
    chk("R8 2D element count", nd, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R7 address stride 4", d_addr[i], 32'h3000_0200 + 32'(4 * i));
      chk("R4 register direction ignored", d_we[i], 0);
    end
    rd(4'd4, v); chk("R8 2D final X", v, 0);
    rd(4'd5, v); chk("R8 2D final Y", v, 16'd1);
    rd(4'd2, v); chk("R8 2D final address", v, 16'h0218);
    chk("R11 row interrupts", nirq, 3);
    chk("R11 no interrupt during fetch", early_irq, 0);
    rd(4'd1, v); chk("R9 run clear after 2D", v, 0);
  endtask

  task automatic t_desc_nocfg();
    logic [15:0] v;
    clr_log();
    dbase = 32'h0000_0080;
    desc_mem[0] = 16'h0010; desc_mem[1] = 16'h0000;
    desc_mem[2] = 16'd4;    desc_mem[3] = 16'd7;
    wr(4'd1, 16'h0080); wr(4'd2, 16'h0000);
    wr(4'd0, 16'h0103);            // mode 1, en, dir_wr, wsize 0, 1D, no irq
    bus_gnt = 1'b1; repeat (4) @(posedge clk); #1 bus_gnt = 1'b0;
    chk("R3 four words without config", nf, 4);
    chk("R3 last word address", f_addr[3], 32'h0000_0086);
    wr(4'd5, 16'h0099); wr(4'd0, 16'h0000);
    rd(4'd10, v); chk("R12 X write ignored while running", v, 16'd4);
    rd(4'd0, v);  chk("R12 config write ignored while running", v, 16'h0103);
    rd(4'd1, v);  chk("R3 run kept after fetch", v, 16'h0001);
    bus_gnt = 1'b1;
    wait_data(4);
    chk("R4 mode 1 element count", nd, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R7 address stride 1", d_addr[i], 32'h0000_0010 + 32'(i));
      chk("R4 mode 1 register direction used", d_we[i], 1);
    end
    chk("R11 no interrupt when disabled", nirq, 0);
    rd(4'd5, v); chk("R8 1D Y from descriptor", v, 16'd7);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) desc_mem[i] = '0;
    clr_log();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_reg_1d();
    t_desc_cfg();
    t_desc_nocfg();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule